// File: doc/BRIEF.md
# Switch Configuration Access Router

This block sits inside a multi-port switch and steers every register access to the right per-port register set. Each port owns a 4-KB configuration space, seen as 1024 DWords indexed by a 10-bit value: a 6-bit register number in the low bits and a 4-bit extended register number above it. Requests come in three kinds. A legacy configuration request only reaches the lowest 64 DWords, because its extended number is ignored. An enhanced configuration request reaches the whole space except the DWords that a parameter bitmap marks as device-specific. A memory request falls in a 128-KB window that holds all ports' spaces back to back and reaches every DWord.

Configuration requests are routed by bus and device number. The upstream port answers on its primary bus as device 0. The downstream ports share one internal bus and are told apart by device number. Both bus numbers and the 64-bit window base are held in the upstream port's own registers, so software programs them through ordinary accesses. A small per-port register file stands in for the real register contents. Every accepted request produces one response in the next cycle. The response carries a status, the target port, the DWord index and the read data.

Top module: `cfg_access_router`

## Requirements
- R1: While reset is asserted and until the reset release has passed through its synchronizer, `req_ready` and `rsp_valid` are 0. After that `req_ready` stays 1, and every register reads as 0.
- R2: A legacy request (`req_kind`=0) targets DWord index {4'b0, `req_reg`}. `req_ext` has no effect on it.
- R3: An enhanced request (`req_kind`=1) targets DWord index {`req_ext`, `req_reg`} over the full 0..1023 range.
- R4: An enhanced request whose index is marked in the device-specific bitmap (by default indices 64..95) returns `rsp_status`=2 and read data FFFF_FFFFh, and a write of that kind leaves the register unchanged.
- R5: A memory request (`req_kind`=3'd2, `req_addr` holding byte-address bits 63:2) hits when address bits 63:17 equal the window base. The base is upstream DWord 5 as bits 63:32 and upstream DWord 4 bits 31:17 as bits 31:17. Address bits 16:12 select the port and bits 11:2 the DWord. Marked DWords are reachable this way.
- R6: A memory request outside the window, a window slot at or above the implemented port count, or `req_kind`=3 returns `rsp_status`=1 and FFFF_FFFFh, and drops any write.
- R7: A configuration request routes to port 0 when the bus equals upstream DWord 6 bits 7:0 and the device is 0. Otherwise it routes to port d+1 when the bus equals DWord 6 bits 15:8 and the device d is below the port count minus one. Any other request returns status 1 with FFFF_FFFFh and drops its write.
- R8: A write updates only the bytes whose `req_be` bit is set (bit n covers data bits 8n+7:8n).
- R9: Every accepted request gives exactly one response, with `rsp_valid` high in the cycle after acceptance. The status is 0 for success, and on success `rsp_port` and `rsp_dw` name the target. A successful write returns data 0, and on status 1 port and index read 0.
- R10: DWord indices at or above the stored depth (128 by default) read as 0 with status 0, and writes to them have no effect.
- R11: Bits 16:0 of upstream DWord 4 always read 0, which keeps the window 128-KB aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 legacy, 1 enhanced, 2 memory, 3 reserved |
| req_write | input | 1 | 1 write, 0 read |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| req_bus | input | 8 | Configuration bus number |
| req_dev | input | 5 | Configuration device number |
| req_reg | input | 6 | Register number (low index bits) |
| req_ext | input | 4 | Extended register number (high index bits) |
| req_addr | input | 62 | Memory DWord address (byte address bits 63:2) |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 ok, 1 unsupported, 2 blocked |
| rsp_port | output | 5 | Target port |
| rsp_dw | output | 10 | Target DWord index |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume that `req_kind` is stable and known whenever a request is accepted, and that nothing drives a request before the synchronized reset releases `req_ready`. The bench honours both. It changes inputs only on the falling edge, holds `req_valid` low through reset, and waits for `req_ready` before the first request. The random stimulus never rewrites the upstream bus and base registers after the directed setup. Without that rule the window would move and most memory requests would miss, so any random write aimed at those three DWords is sent as a read.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  localparam int DW_IDX_W   = 10;
  localparam int SPACE_LOG2 = 12;
  localparam int WIN_LOG2   = 17;
  localparam int SLOT_W     = WIN_LOG2 - SPACE_LOG2;
  localparam int DW_COUNT   = 1 << DW_IDX_W;
  localparam int ADDR_W     = 62;

  // Upstream register indices that configure routing
  localparam int BASE_LO_DW = 4;
  localparam int BASE_HI_DW = 5;
  localparam int BUSNUM_DW  = 6;

  localparam logic [DW_COUNT-1:0] VSPEC_DEFAULT =
    {{(DW_COUNT-96){1'b0}}, 32'hFFFF_FFFF, 64'h0};

  typedef enum logic [1:0] {
    KIND_LEGACY = 2'd0,
    KIND_ENH    = 2'd1,
    KIND_MEM    = 2'd2,
    KIND_RSVD   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_UR      = 2'd1,
    ST_BLOCKED = 2'd2
  } rsp_status_e;

  typedef struct packed {
    rsp_status_e          status;
    logic [SLOT_W-1:0]    port;
    logic [DW_IDX_W-1:0]  dw;
  } route_t;

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] res;
    res = old_v;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) res[8*b +: 8] = new_v[8*b +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
  import cfgr_pkg::*;
#(
  parameter int                   NUM_PORTS = 8,
  parameter logic [DW_COUNT-1:0]  VSPEC_MAP = VSPEC_DEFAULT
) (
  input  req_kind_e              kind,
  input  logic [7:0]             bus,
  input  logic [4:0]             dev,
  input  logic [5:0]             reg_num,
  input  logic [3:0]             ext_num,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             pri_bus,
  input  logic [7:0]             sec_bus,
  input  logic [63:WIN_LOG2]     win_base,
  output route_t                 route
);
  localparam logic [5:0]        DN_LIMIT   = 6'(NUM_PORTS - 1);
  localparam logic [SLOT_W:0]   SLOT_LIMIT = (SLOT_W+1)'(NUM_PORTS);

  logic [DW_IDX_W-1:0] cfg_dw;
  logic                up_hit;
  logic                dn_hit;
  logic [SLOT_W-1:0]   dn_port;
  logic                win_hit;
  logic [SLOT_W-1:0]   win_slot;
  logic                slot_ok;

  always_comb begin
    cfg_dw   = (kind == KIND_LEGACY) ? {4'b0000, reg_num} : {ext_num, reg_num};
    up_hit   = (bus == pri_bus) && (dev == 5'd0);
    dn_hit   = !up_hit && (bus == sec_bus) && ({1'b0, dev} < DN_LIMIT);
    dn_port  = SLOT_W'(dev) + SLOT_W'(1);
    win_hit  = (addr[ADDR_W-1:WIN_LOG2-2] == win_base);
    win_slot = addr[WIN_LOG2-3:SPACE_LOG2-2];
    slot_ok  = ({1'b0, win_slot} < SLOT_LIMIT);
  end

  always_comb begin
    route.status = ST_UR;
    route.port   = '0;
    route.dw     = '0;
    unique case (kind)
      KIND_LEGACY, KIND_ENH: begin
        if (up_hit || dn_hit) begin
          route.port = up_hit ? '0 : dn_port;
          route.dw   = cfg_dw;
          if (kind == KIND_ENH && VSPEC_MAP[cfg_dw]) route.status = ST_BLOCKED;
          else                                      route.status = ST_OK;
        end
      end
      KIND_MEM: begin
        if (win_hit && slot_ok) begin
          route.status = ST_OK;
          route.port   = win_slot;
          route.dw     = addr[SPACE_LOG2-3:0];
        end
      end
      default: route.status = ST_UR;
    endcase
  end
endmodule

// File: rtl/cfgr_regfile.sv
module cfgr_regfile
  import cfgr_pkg::*;
#(
  parameter int NUM_PORTS   = 8,
  parameter int STORE_DEPTH = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_port,
  input  logic [DW_IDX_W-1:0]  wr_dw,
  input  logic [3:0]           wr_be,
  input  logic [31:0]          wr_data,
  input  logic [SLOT_W-1:0]    rd_port,
  input  logic [DW_IDX_W-1:0]  rd_dw,
  output logic [31:0]          rd_data,
  output logic [7:0]           pri_bus,
  output logic [7:0]           sec_bus,
  output logic [63:WIN_LOG2]   win_base
);
  localparam int                 ST_W      = $clog2(STORE_DEPTH);
  localparam logic [DW_IDX_W:0]  DEPTH_LIM = (DW_IDX_W+1)'(STORE_DEPTH);
  localparam logic [31:0]        BASE_KEEP = ~((32'd1 << WIN_LOG2) - 32'd1);

  logic              wr_in_range;
  logic              rd_in_range;
  logic [ST_W-1:0]   wr_idx;
  logic [ST_W-1:0]   rd_idx;
  logic [31:0]       rd_per_port [NUM_PORTS];

  assign wr_in_range = ({1'b0, wr_dw} < DEPTH_LIM);
  assign rd_in_range = ({1'b0, rd_dw} < DEPTH_LIM);
  assign wr_idx      = wr_dw[ST_W-1:0];
  assign rd_idx      = rd_dw[ST_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [31:0] mem_q [STORE_DEPTH];
    logic        sel_wr;
    logic [31:0] keep_mask;
    logic [31:0] wr_next;

    assign sel_wr    = wr_en && wr_in_range && (wr_port == SLOT_W'(p));
    assign keep_mask = (p == 0 && wr_idx == ST_W'(BASE_LO_DW)) ? BASE_KEEP : '1;
    assign wr_next   = be_merge(mem_q[wr_idx], wr_data, wr_be) & keep_mask;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < STORE_DEPTH; i++) mem_q[i] <= '0;
      end else if (sel_wr) begin
        mem_q[wr_idx] <= wr_next;
      end
    end

    assign rd_per_port[p] = mem_q[rd_idx];

    if (p == 0) begin : g_up
      assign pri_bus  = mem_q[BUSNUM_DW][7:0];
      assign sec_bus  = mem_q[BUSNUM_DW][15:8];
      assign win_base = {mem_q[BASE_HI_DW], mem_q[BASE_LO_DW][31:WIN_LOG2]};
    end
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rd_in_range && rd_port == SLOT_W'(p)) rd_data = rd_per_port[p];
    end
  end
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfgr_pkg::*;
#(
  parameter int                  NUM_PORTS   = 8,
  parameter int                  STORE_DEPTH = 128,
  parameter logic [DW_COUNT-1:0] VSPEC_MAP   = VSPEC_DEFAULT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic               req_write,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  input  logic [7:0]         req_bus,
  input  logic [4:0]         req_dev,
  input  logic [5:0]         req_reg,
  input  logic [3:0]         req_ext,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [4:0]         rsp_port,
  output logic [9:0]         rsp_dw,
  output logic [31:0]        rsp_rdata
);
  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic ready_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ready_q <= 1'b0;
    else             ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  logic               accept;
  route_t             route;
  logic [7:0]         pri_bus;
  logic [7:0]         sec_bus;
  logic [63:WIN_LOG2] win_base;
  logic [31:0]        rd_data;
  logic               wr_en;

  assign accept = req_valid && ready_q;
  assign wr_en  = accept && req_write && (route.status == ST_OK);

  cfgr_decode #(
    .NUM_PORTS (NUM_PORTS),
    .VSPEC_MAP (VSPEC_MAP)
  ) u_decode (
    .kind     (req_kind_e'(req_kind)),
    .bus      (req_bus),
    .dev      (req_dev),
    .reg_num  (req_reg),
    .ext_num  (req_ext),
    .addr     (req_addr),
    .pri_bus  (pri_bus),
    .sec_bus  (sec_bus),
    .win_base (win_base),
    .route    (route)
  );

  cfgr_regfile #(
    .NUM_PORTS   (NUM_PORTS),
    .STORE_DEPTH (STORE_DEPTH)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .wr_port  (route.port),
    .wr_dw    (route.dw),
    .wr_be    (req_be),
    .wr_data  (req_wdata),
    .rd_port  (route.port),
    .rd_dw    (route.dw),
    .rd_data  (rd_data),
    .pri_bus  (pri_bus),
    .sec_bus  (sec_bus),
    .win_base (win_base)
  );

  // Response next state
  logic                nxt_valid;
  rsp_status_e         nxt_status;
  logic [SLOT_W-1:0]   nxt_port;
  logic [DW_IDX_W-1:0] nxt_dw;
  logic [31:0]         nxt_rdata;

  always_comb begin
    nxt_valid  = accept;
    nxt_status = route.status;
    nxt_port   = (route.status == ST_UR) ? '0 : route.port;
    nxt_dw     = (route.status == ST_UR) ? '0 : route.dw;
    if (route.status != ST_OK) nxt_rdata = '1;
    else if (req_write)        nxt_rdata = '0;
    else                       nxt_rdata = rd_data;
  end

  // Response registers
  logic                valid_q;
  rsp_status_e         status_q;
  logic [SLOT_W-1:0]   port_q;
  logic [DW_IDX_W-1:0] dw_q;
  logic [31:0]         rdata_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q  <= 1'b0;
      status_q <= ST_OK;
      port_q   <= '0;
      dw_q     <= '0;
      rdata_q  <= '0;
    end else begin
      valid_q <= nxt_valid;
      if (accept) begin
        status_q <= nxt_status;
        port_q   <= nxt_port;
        dw_q     <= nxt_dw;
        rdata_q  <= nxt_rdata;
      end
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_status = status_q;
  assign rsp_port   = port_q;
  assign rsp_dw     = dw_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker
  import cfgr_pkg::*;
#(
  parameter int                  NUM_PORTS = 8,
  parameter logic [DW_COUNT-1:0] VSPEC_MAP = VSPEC_DEFAULT
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_kind,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [4:0]  rsp_port,
  input logic [9:0]  rsp_dw,
  input logic [31:0] rsp_rdata
);
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready); // R1

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R9

  AST_RSP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready)); // R9

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3)); // R9

  AST_LEGACY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_kind) == 2'd0 && rsp_status == 2'd0) |-> (rsp_dw[9:6] == 4'd0)); // R2

  AST_ENH_NOT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_kind) == 2'd1 && rsp_status == 2'd0) |-> !VSPEC_MAP[rsp_dw]); // R4

  AST_REJECT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_rdata == 32'hFFFF_FFFF)); // R6

  AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> ({27'd0, rsp_port} < NUM_PORTS)); // R7
endmodule

bind cfg_access_router cfgr_checker #(
  .NUM_PORTS (NUM_PORTS),
  .VSPEC_MAP (VSPEC_MAP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_port   (rsp_port),
  .rsp_dw     (rsp_dw),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/cfg_access_router_bench.sv
module cfg_access_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [5:0]  req_reg = '0;
  logic [3:0]  req_ext = '0;
  logic [61:0] req_addr = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [4:0]  rsp_port;
  logic [9:0]  rsp_dw;
  logic [31:0] rsp_rdata;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [31:0] sh [8][128];

  always #10 clk = ~clk;

  cfg_access_router u_cfg_access_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .req_bus(req_bus), .req_dev(req_dev), .req_reg(req_reg), .req_ext(req_ext),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_port(rsp_port), .rsp_dw(rsp_dw), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] win_base_byte();
    return {sh[0][5], sh[0][4][31:17], 17'd0};
  endfunction

  // Reference routing from the requirements
  task automatic predict(input int kind, input logic [7:0] bus, input logic [4:0] dev,
                         input logic [5:0] rg, input logic [3:0] ext, input logic [63:0] addr,
                         output int st, output int port, output int dw);
    logic [7:0] pri, sec;
    pri = sh[0][6][7:0];
    sec = sh[0][6][15:8];
    st = 1; port = 0; dw = 0;
    if (kind == 0 || kind == 1) begin
      int d;
      d = (kind == 0) ? int'(rg) : int'({ext, rg});
      if (bus == pri && dev == 0) begin st = 0; port = 0; dw = d; end
      else if (bus == sec && dev < 7) begin st = 0; port = int'(dev) + 1; dw = d; end
      if (st == 0 && kind == 1 && d >= 64 && d <= 95) st = 2;
    end else if (kind == 2) begin
      if (addr[63:17] == win_base_byte() >> 17 && addr[16:12] < 8) begin
        st = 0; port = int'(addr[16:12]); dw = int'(addr[11:2]);
      end
    end
  endtask

  task automatic do_req(input int kind, input bit wr, input logic [3:0] be, input logic [31:0] wd,
                        input logic [7:0] bus, input logic [4:0] dev, input logic [5:0] rg,
                        input logic [3:0] ext, input logic [63:0] addr, input string tag,
                        output logic [31:0] rd);
    int st, port, dw;
    logic [31:0] exp_rd;
    predict(kind, bus, dev, rg, ext, addr, st, port, dw);
    if (st != 0)      exp_rd = 32'hFFFF_FFFF;
    else if (wr)      exp_rd = 32'h0;
    else if (dw < 128) exp_rd = sh[port][dw];
    else              exp_rd = 32'h0;
    req_valid = 1'b1; req_kind = 2'(kind); req_write = wr; req_be = be; req_wdata = wd;
    req_bus = bus; req_dev = dev; req_reg = rg; req_ext = ext; req_addr = addr[63:2];
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " status"}, 64'(rsp_status), 64'(st));
    chk({tag, " port"}, 64'(rsp_port), 64'(port));
    chk({tag, " dw"}, 64'(rsp_dw), 64'(dw));
    chk({tag, " rdata"}, 64'(rsp_rdata), 64'(exp_rd));
    rd = rsp_rdata;
    if (wr && st == 0 && dw < 128) begin
      logic [31:0] nv;
      nv = sh[port][dw];
      for (int b = 0; b < 4; b++) if (be[b]) nv[8*b +: 8] = wd[8*b +: 8];
      if (port == 0 && dw == 4) nv = nv & 32'hFFFE_0000;
      sh[port][dw] = nv;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] base;
    void'($urandom(32'd20240611));
    for (int p = 0; p < 8; p++) for (int i = 0; i < 128; i++) sh[p][i] = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 64'(req_ready), 64'd0);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    do_req(1, 0, 4'hF, 0, 8'd0, 5'd0, 6'd10, 4'd9, 0, "R1 zero read", rd);
    chk("R1 reg reads zero", 64'(rd), 64'd0);

    // R7 bus numbers: primary 0, internal 1
    do_req(0, 1, 4'hF, 32'h0000_0100, 8'd0, 5'd0, 6'd6, 4'd0, 0, "R7 set bus", rd);
    // R11 base low bits forced to zero
    do_req(0, 1, 4'hF, 32'hFFFF_FFFF, 8'd0, 5'd0, 6'd4, 4'd0, 0, "R11 write", rd);
    do_req(0, 0, 4'hF, 0, 8'd0, 5'd0, 6'd4, 4'd0, 0, "R11 read", rd);
    chk("R11 low bits zero", 64'(rd), 64'h0000_0000_FFFE_0000);
    do_req(0, 1, 4'hF, 32'h8004_0000, 8'd0, 5'd0, 6'd4, 4'd0, 0, "R5 base lo", rd);
    do_req(0, 1, 4'hF, 32'h0000_0001, 8'd0, 5'd0, 6'd5, 4'd0, 0, "R5 base hi", rd);
    base = win_base_byte();
    chk("R5 base model", base, 64'h0000_0001_8004_0000);

    // R2 legacy ignores ext
    do_req(0, 1, 4'hF, 32'h0000_A5A5, 8'd1, 5'd2, 6'd5, 4'd3, 0, "R2 legacy write", rd);
    do_req(1, 0, 4'hF, 0, 8'd1, 5'd2, 6'd5, 4'd0, 0, "R2 enhanced readback", rd);
    chk("R2 ext ignored", 64'(rd), 64'h0000_A5A5);

    // R4 / R5 device-specific index 74
    do_req(1, 1, 4'hF, 32'hDEAD_BEEF, 8'd1, 5'd0, 6'd10, 4'd1, 0, "R4 blocked write", rd);
    do_req(2, 0, 4'hF, 0, 0, 0, 0, 0, base + 64'h1000 + 64'd296, "R4 write dropped", rd);
    chk("R4 value unchanged", 64'(rd), 64'd0);
    do_req(2, 1, 4'hF, 32'h0000_1234, 0, 0, 0, 0, base + 64'h1000 + 64'd296, "R5 mem write", rd);
    do_req(2, 0, 4'hF, 0, 0, 0, 0, 0, base + 64'h1000 + 64'd296, "R5 mem read", rd);
    chk("R5 vendor reg via window", 64'(rd), 64'h1234);
    do_req(1, 0, 4'hF, 0, 8'd1, 5'd0, 6'd10, 4'd1, 0, "R4 blocked read", rd);

    // R3 full range, R10 beyond stored depth
    do_req(1, 1, 4'hF, 32'h7777_0001, 8'd1, 5'd6, 6'd63, 4'd1, 0, "R3 dw127 write", rd);
    do_req(2, 0, 4'hF, 0, 0, 0, 0, 0, base + 64'h7000 + 64'd508, "R3 dw127 via window", rd);
    do_req(1, 1, 4'hF, 32'h5555_5555, 8'd1, 5'd3, 6'd0, 4'd2, 0, "R10 write dw128", rd);
    do_req(1, 0, 4'hF, 0, 8'd1, 5'd3, 6'd0, 4'd2, 0, "R10 read dw128", rd);
    chk("R10 reads zero", 64'(rd), 64'd0);
    do_req(1, 0, 4'hF, 0, 8'd1, 5'd3, 6'd63, 4'd15, 0, "R3 dw1023", rd);

    // R6 misses
    do_req(2, 1, 4'hF, 32'h1, 0, 0, 0, 0, base + 64'h8000, "R6 slot 8", rd);
    do_req(2, 0, 4'hF, 0, 0, 0, 0, 0, base + 64'h2_0000, "R6 outside window", rd);
    do_req(3, 1, 4'hF, 32'h1, 8'd1, 5'd0, 6'd1, 4'd0, 0, "R6 reserved kind", rd);
    do_req(0, 0, 4'hF, 0, 8'd1, 5'd0, 6'd1, 4'd0, 0, "R6 no side effect", rd);
    chk("R6 reg untouched", 64'(rd), 64'd0);

    // R7 routing misses and last downstream port
    do_req(0, 1, 4'hF, 32'h9, 8'd9, 5'd0, 6'd8, 4'd0, 0, "R7 unknown bus", rd);
    do_req(0, 0, 4'hF, 0, 8'd1, 5'd7, 6'd8, 4'd0, 0, "R7 dev beyond ports", rd);
    do_req(0, 0, 4'hF, 0, 8'd0, 5'd1, 6'd8, 4'd0, 0, "R7 upstream dev1", rd);
    do_req(0, 1, 4'hF, 32'hCAFE, 8'd1, 5'd6, 6'd8, 4'd0, 0, "R7 dev6 to port7", rd);

    // R8 byte enables
    do_req(0, 1, 4'hF, 32'hFFFF_FFFF, 8'd1, 5'd1, 6'd20, 4'd0, 0, "R8 fill", rd);
    do_req(0, 1, 4'b0101, 32'h1122_3344, 8'd1, 5'd1, 6'd20, 4'd0, 0, "R8 partial", rd);
    do_req(0, 0, 4'hF, 0, 8'd1, 5'd1, 6'd20, 4'd0, 0, "R8 read", rd);
    chk("R8 merged", 64'(rd), 64'hFF22_FF44);

    // R9 no response without request
    @(negedge clk);
    chk("R9 idle no response", 64'(rsp_valid), 64'd0);

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      int kind, st, port, dw;
      bit wr;
      logic [7:0] bus;
      logic [4:0] dev;
      logic [5:0] rg;
      logic [3:0] ext;
      logic [63:0] addr;
      kind = int'($urandom % 4);
      if (kind == 3 && ($urandom % 4) != 0) kind = 2;
      wr  = 1'($urandom % 2);
      case ($urandom % 3)
        0: bus = sh[0][6][7:0];
        1: bus = sh[0][6][15:8];
        default: bus = 8'($urandom);
      endcase
      dev = 5'($urandom % 9);
      rg  = 6'($urandom);
      ext = ($urandom % 2) ? 4'd0 : 4'($urandom);
      if (($urandom % 4) != 0) addr = win_base_byte() + 64'({$urandom} % 32'h2_0000);
      else                     addr = {$urandom, $urandom};
      predict(kind, bus, dev, rg, ext, addr, st, port, dw);
      if (st == 0 && port == 0 && dw >= 4 && dw <= 6) wr = 0;
      do_req(kind, wr, 4'($urandom), $urandom, bus, dev, rg, ext, addr, "R9 random", rd);
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        chk("R9 random idle", 64'(rsp_valid), 64'd0);
      end
    end
    finish_up();
  end
endmodule